// File: doc/BRIEF.md
# Dual-Mode FIFO Status Flag Generator

A dual-clock first-in first-out buffer for 18-bit words. Its depth is a parameter. A write port runs on its own clock and a read port runs on a second, unrelated clock. Each port derives its status flags from a word count. That count is computed locally from the other port's pointer, which crosses the clock boundary as Gray code through a two-stage synchronizer.

A static mode input selects one of two read behaviours. In standard mode, every word, the first one included, must be requested with the read enable. In fall-through mode, the oldest word is presented on the output register without a request, and a read enable consumes it. Because the output register also holds a word in this mode, capacity grows by one. Every count threshold moves up by one, and the two boundary flags turn into ready indications.

The empty and full offsets arrive as plain inputs and are compared against the live counts. The mode input must be changed only while reset is asserted.

Top module: `dual_mode_fifo`

## Requirements
- R1: After reset, half_n and afull_n are 1, aempty_n is 0 and dout is 0. In standard mode (fwft=0), wr_stat is 1 and rd_stat is 0. In fall-through mode (fwft=1), wr_stat is 0 and rd_stat is 1.
- R2: In standard mode, with c the stored word count, aempty_n is 0 exactly when c <= empty_off, half_n is 0 exactly when c > DEPTH/2, and afull_n is 0 exactly when c >= DEPTH - full_off.
- R3: In standard mode, wr_stat is 0 (full) exactly when c equals DEPTH. In fall-through mode, wr_stat is 1 (not ready) exactly when c equals DEPTH+1, which is the capacity in that mode.
- R4: In fall-through mode, c counts the word held in the output register. The aempty_n, half_n and afull_n thresholds are each one word higher than in R2. rd_stat is 0 (ready) exactly while a word is presented on dout.
- R5: Every accepted write is returned exactly once and in write order, on dout, in both modes.
- R6: A write requested while the write-side flag shows full (or not ready) stores nothing. The count and the later read sequence are unchanged.
- R7: In standard mode, a read requested while rd_stat is 0 (empty) leaves dout and the flags unchanged.
- R8: In standard mode, dout keeps its value on every read-clock edge where rd_en is 0.
- R9: In fall-through mode, the first word written into an empty buffer appears on dout, with rd_stat falling to 0, at the third read-clock rising edge after the write edge, and not earlier. rd_en stays 0 throughout.
- R10: In standard mode, a stored word does not reach dout until it is requested: dout stays 0 after reset even though rd_stat is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft | input | 1 | 0 selects standard mode, 1 selects fall-through mode; static outside reset |
| wr_en | input | 1 | Write request, active high |
| din | input | WORD_W | Write data |
| rd_en | input | 1 | Read request, active high |
| dout | output | WORD_W | Output register |
| empty_off | input | log2(DEPTH) | Almost-empty offset |
| full_off | input | log2(DEPTH) | Almost-full offset |
| wr_stat | output | 1 | Standard mode: 0 when full; fall-through mode: 1 when not ready |
| rd_stat | output | 1 | Standard mode: 0 when empty; fall-through mode: 1 when no word presented |
| half_n | output | 1 | 0 when more than half full (write clock) |
| aempty_n | output | 1 | 0 when almost empty (read clock) |
| afull_n | output | 1 | 0 when almost full (write clock) |

## Verification
A corrupted pointer or synchronized copy shows up first as a wrong threshold flag after the clock domains settle. It shows up next as a missing, duplicated or reordered word in the scoreboard when the buffer is drained. A fault in the fall-through head logic either moves the first-word arrival off the third read edge or breaks the capacity of DEPTH+1 words. Each of these is visible at the ports within a few cycles of the write or read that exposes it. Overflow and underflow of the pointers are also caught in the cycle they happen, by checks beside the pointer logic.

// File: rtl/dflag_pkg.sv
package dflag_pkg;

  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;

  // k is 1 in fall-through mode: the output register holds one extra word
  function automatic logic ae_low(input int cnt, input int off, input int k);
    return cnt <= off + k;
  endfunction

  function automatic logic hf_low(input int cnt, input int depth, input int k);
    return cnt > depth / 2 + k;
  endfunction

  function automatic logic af_low(input int cnt, input int depth, input int off, input int k);
    return cnt >= depth - off + k;
  endfunction

  // total count at capacity, or RAM itself fully occupied
  function automatic logic full_hit(input int cnt, input int occ, input int depth, input int k);
    return (cnt >= depth + k) || (occ >= depth);
  endfunction

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dflag_gray_sync.sv
module dflag_gray_sync #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  import dflag_pkg::*;

  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out = PW'(gray2bin(32'(stage2)));

endmodule

// File: rtl/dflag_ram.sv
module dflag_ram #(
  parameter int W  = 18,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int NWORDS = 1 << AW;

  logic [W-1:0] mem [NWORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dflag_wr.sv
module dflag_wr #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = 7
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          wr_en,
  input  logic [AW-1:0] full_off,
  input  logic [PW-1:0] cons_bin,
  input  logic [PW-1:0] rram_bin,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wptr_gray,
  output logic          wr_fire,
  output logic          wr_stat,
  output logic          half_n,
  output logic          afull_n
);
  import dflag_pkg::*;

  fifo_mode_e    mode;
  int            k;
  logic [PW-1:0] cnt, occ, wptr_nx;
  logic          full_int;

  assign mode = fifo_mode_e'(fwft);

  always_comb begin
    k        = (mode == MODE_FWFT) ? 1 : 0;
    cnt      = wptr - cons_bin;
    occ      = wptr - rram_bin;
    full_int = full_hit(int'(cnt), int'(occ), DEPTH, k);
    wr_fire  = wr_en && !full_int;
    wptr_nx  = wptr + PW'(wr_fire);
    wr_stat  = (mode == MODE_FWFT) ? full_int : !full_int;
    half_n   = !hf_low(int'(cnt), DEPTH, k);
    afull_n  = !af_low(int'(cnt), DEPTH, int'(full_off), k);
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      wptr_gray <= '0;
    end else begin
      wptr      <= wptr_nx;
      wptr_gray <= PW'(bin2gray(32'(wptr_nx)));
    end
  end

  // R6
  wr_ptr_order_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    occ <= PW'(DEPTH));

  // R3
  full_by_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(full_int) |-> $past(wr_fire));

endmodule

// File: rtl/dflag_rd.sv
module dflag_rd #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = 7,
  parameter int W     = 18
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic [AW-1:0] empty_off,
  input  logic [PW-1:0] wptr_bin,
  input  logic [W-1:0]  ram_q,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr_gray,
  output logic [PW-1:0] cons_gray,
  output logic [W-1:0]  dout,
  output logic          rd_stat,
  output logic          aempty_n
);
  import dflag_pkg::*;

  fifo_mode_e    mode;
  int            k;
  logic [PW-1:0] rptr, rptr_nx, cons_nx, ram_cnt, total;
  logic          head_v, head_nx, ld_fire, take;

  assign mode = fifo_mode_e'(fwft);

  always_comb begin
    k       = (mode == MODE_FWFT) ? 1 : 0;
    ram_cnt = wptr_bin - rptr;
    if (mode == MODE_FWFT) begin
      ld_fire = (ram_cnt != '0) && (!head_v || rd_en);
      take    = rd_en && head_v;
      head_nx = ld_fire ? 1'b1 : (take ? 1'b0 : head_v);
      rd_stat = !head_v;
    end else begin
      ld_fire = rd_en && (ram_cnt != '0);
      take    = ld_fire;
      head_nx = 1'b0;
      rd_stat = (ram_cnt != '0);
    end
    rptr_nx  = rptr + PW'(ld_fire);
    cons_nx  = rptr_nx - PW'(head_nx);
    total    = ram_cnt + PW'(head_v);
    aempty_n = !ae_low(int'(total), int'(empty_off), k);
  end

  assign raddr = rptr[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      head_v    <= 1'b0;
      rptr_gray <= '0;
      cons_gray <= '0;
      dout      <= '0;
    end else begin
      rptr      <= rptr_nx;
      head_v    <= head_nx;
      rptr_gray <= PW'(bin2gray(32'(rptr_nx)));
      cons_gray <= PW'(bin2gray(32'(cons_nx)));
      if (ld_fire) dout <= ram_q;
    end
  end

  // R7
  rd_ptr_order_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    ram_cnt <= PW'(DEPTH));

  // R8
  dout_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode == MODE_STD) && !rd_en |=> $stable(dout));

  // R9
  head_keep_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode == MODE_FWFT) && head_v && !rd_en |=> head_v);

  // R5
  take_needs_head_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode == MODE_FWFT) && take |-> !rd_stat);

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 18,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] din,
  input  logic              rd_en,
  output logic [WORD_W-1:0] dout,
  input  logic [AW-1:0]     empty_off,
  input  logic [AW-1:0]     full_off,
  output logic              wr_stat,
  output logic              rd_stat,
  output logic              half_n,
  output logic              aempty_n,
  output logic              afull_n
);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wptr_w, wptr_gray, wptr_r;
  logic [PW-1:0]     cons_gray, cons_w, rptr_gray, rram_w;
  logic [AW-1:0]     raddr;
  logic [WORD_W-1:0] ram_q;
  logic              wr_fire;

  dflag_gray_sync #(.PW(PW)) u_sync_wptr (
    .clk(rclk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wptr_r));

  dflag_gray_sync #(.PW(PW)) u_sync_cons (
    .clk(wclk), .rst_n(rst_n), .gray_in(cons_gray), .bin_out(cons_w));

  dflag_gray_sync #(.PW(PW)) u_sync_rram (
    .clk(wclk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rram_w));

  dflag_ram #(.W(WORD_W), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(wptr_w[AW-1:0]), .wdata(din),
    .raddr(raddr), .rdata(ram_q));

  dflag_wr #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .fwft(fwft), .wr_en(wr_en),
    .full_off(full_off), .cons_bin(cons_w), .rram_bin(rram_w),
    .wptr(wptr_w), .wptr_gray(wptr_gray), .wr_fire(wr_fire),
    .wr_stat(wr_stat), .half_n(half_n), .afull_n(afull_n));

  dflag_rd #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .W(WORD_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .rd_en(rd_en),
    .empty_off(empty_off), .wptr_bin(wptr_r), .ram_q(ram_q),
    .raddr(raddr), .rptr_gray(rptr_gray), .cons_gray(cons_gray),
    .dout(dout), .rd_stat(rd_stat), .aempty_n(aempty_n));

endmodule

// File: tb/tb_dual_mode_fifo.sv
module tb_dual_mode_fifo;
  localparam int D  = 16;
  localparam int NO = 3;
  localparam int MO = 2;

  logic        wclk = 1'b0, rclk = 1'b0;
  logic        rst_n, fwft, wr_en, rd_en;
  logic [17:0] din, dout;
  logic [3:0]  eoff, foff;
  logic        wr_stat, rd_stat, half_n, aempty_n, afull_n;
  logic [4:0]  obs;

  int          checks = 0, errors = 0, pops = 0;
  logic [17:0] sbq[$];
  logic [17:0] last_pop = '0;
  logic [17:0] hold_v;
  logic        pend = 1'b0;
  logic        done = 1'b0;

  dual_mode_fifo #(.DEPTH(D), .WORD_W(18)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .wr_en(wr_en),
    .din(din), .rd_en(rd_en), .dout(dout), .empty_off(eoff), .full_off(foff),
    .wr_stat(wr_stat), .rd_stat(rd_stat), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n));

  assign obs = {rd_stat, wr_stat, half_n, aempty_n, afull_n};

  always #4 wclk = ~wclk;
  initial begin
    #3;
    forever #4 rclk = ~rclk;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {rd_stat, wr_stat, half_n, aempty_n, afull_n} for count c
  function automatic logic [4:0] model(input int c, input int k);
    logic rs, ws;
    rs = (k == 1) ? (c == 0) : (c != 0);
    ws = (k == 1) ? (c == D + 1) : (c != D);
    return {rs, ws, !(c > D / 2 + k), !(c <= NO + k), !(c >= D - MO + k)};
  endfunction

  task automatic pop_cmp();
    logic [17:0] e;
    if (sbq.size() == 0) begin
      chk(1'b0, "R5 extra word", 32'(dout), 32'h0);
    end else begin
      e = sbq.pop_front();
      chk(dout == e, "R5 order", 32'(dout), 32'(e));
      last_pop = e;
      pops++;
    end
  endtask

  // monitor: standard mode word shows one edge after the accepted request;
  // fall-through mode word is consumed while presented
  always @(negedge rclk) begin
    if (rst_n !== 1'b1) begin
      pend = 1'b0;
    end else if (fwft) begin
      if (rd_en && rd_stat == 1'b0) pop_cmp();
    end else begin
      if (pend) pop_cmp();
      pend = rd_en && rd_stat == 1'b1;
    end
  end

  task automatic wr_word(input logic [17:0] d);
    logic rdy;
    @(posedge wclk); #2;
    rdy   = fwft ? (wr_stat == 1'b0) : (wr_stat == 1'b1);
    wr_en = 1'b1;
    din   = d;
    if (rdy) sbq.push_back(d);
    @(posedge wclk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd_one();
    @(posedge rclk); #2;
    rd_en = 1'b1;
    @(posedge rclk); #2;
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);
    #2;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0;
    fwft  = mode;
    repeat (4) @(posedge wclk);
    #2 rst_n = 1'b1;
    settle();
  endtask

  initial begin
    rst_n = 1'b0; fwft = 1'b0; wr_en = 1'b0; rd_en = 1'b0; din = '0;
    eoff = 4'(NO); foff = 4'(MO);

    // ---------------- standard mode ----------------
    do_reset(1'b0);
    chk(obs == model(0, 0), "R1 std flags", 32'(obs), 32'(model(0, 0)));
    chk(dout == '0, "R1 std dout", 32'(dout), 32'h0);

    wr_word(18'h001A5);
    settle();
    chk(dout == '0 && rd_stat == 1'b1, "R10 no fall-through", 32'(dout), 32'h0);
    chk(obs == model(1, 0), "R2 count 1", 32'(obs), 32'(model(1, 0)));
    for (int c = 2; c <= D; c++) begin
      wr_word(18'(c * 1237 + 5));
      settle();
      chk(obs == model(c, 0), "R2 sweep", 32'(obs), 32'(model(c, 0)));
    end
    chk(wr_stat == 1'b0, "R3 std full", 32'(wr_stat), 32'h0);

    wr_word(18'h3FFFF);
    settle();
    chk(obs == model(D, 0), "R6 std write at full", 32'(obs), 32'(model(D, 0)));

    repeat (5) rd_one();
    settle();
    chk(dout == last_pop && pops == 5, "R8 hold", 32'(dout), 32'(last_pop));
    chk(obs == model(D - 5, 0), "R2 after reads", 32'(obs), 32'(model(D - 5, 0)));

    while (rd_stat == 1'b1) rd_one();
    settle();
    chk(pops == D, "R6 std only DEPTH words", 32'(pops), 32'(D));
    chk(sbq.size() == 0 && obs == model(0, 0), "R5 std drained", 32'(obs), 32'(model(0, 0)));

    hold_v = dout;
    @(posedge rclk); #2 rd_en = 1'b1;
    repeat (4) @(posedge rclk);
    #2 rd_en = 1'b0;
    settle();
    chk(dout == hold_v && rd_stat == 1'b0, "R7 read when empty", 32'(dout), 32'(hold_v));

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    pops = 0;
    chk(obs == model(0, 1), "R1 fwft flags", 32'(obs), 32'(model(0, 1)));
    chk(dout == '0, "R1 fwft dout", 32'(dout), 32'h0);

    wr_word(18'h02B3C);
    @(posedge rclk);
    @(posedge rclk); #2;
    chk(rd_stat == 1'b1, "R9 not before third edge", 32'(rd_stat), 32'h1);
    @(posedge rclk); #2;
    chk(rd_stat == 1'b0 && dout == 18'h02B3C, "R9 third edge", 32'(dout), 32'h2B3C);
    settle();
    chk(obs == model(1, 1), "R4 count 1", 32'(obs), 32'(model(1, 1)));

    for (int c = 2; c <= D + 1; c++) begin
      wr_word(18'(c * 811 + 9));
      settle();
      chk(obs == model(c, 1), "R4 sweep", 32'(obs), 32'(model(c, 1)));
    end
    chk(wr_stat == 1'b1, "R3 fwft capacity", 32'(wr_stat), 32'h1);

    wr_word(18'h15555);
    settle();
    chk(obs == model(D + 1, 1), "R6 fwft write at full", 32'(obs), 32'(model(D + 1, 1)));

    while (rd_stat == 1'b0) rd_one();
    settle();
    chk(pops == D + 1, "R5 fwft word count", 32'(pops), 32'(D + 1));
    chk(sbq.size() == 0 && obs == model(0, 1), "R5 fwft drained", 32'(obs), 32'(model(0, 1)));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule